// File: doc/BRIEF.md
# Level-Mapped Interrupt Controller

This block takes eight level-sensitive interrupt requests and presents them to a processor as sixteen priority-level lines. Each request position is wired to one fixed level through a compile-time table. More than one line can be high at the same time. A downstream encoder would reduce these lines to a single level number, but that encoder is not part of this block. Two request positions map to level 0, so they are inert. Level 0 never reaches the processor.

Software sees one byte-wide control register at a single address. The bus has write and read strobes. Bit 0 of the register is a global enable. Bit 6 is hardwired to zero and ignores writes. The pending view has no memory: an interrupt source must hold its request high until it has been serviced. The level lines are registered.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After reset the control register holds 0x01 and every level line is low.
- R2: Each live request position drives its own level line. The mapping from request bit to level is: bit1→1, bit2→4, bit3→6, bit4→8, bit5→10, bit7→14.
- R3: Request bits 0 and 6 map to level 0. They never raise any level line, whether alone or together with other requests.
- R4: A level line follows its request with no memory. It falls on the clock edge after the request drops.
- R5: A write stores the write data with bit 6 cleared, that is data AND 0xBF.
- R6: While control bit 0 is 0, all level lines are low, whatever requests are present. Setting the bit again restores the mapped lines.
- R7: When several live requests are high, the level lines are the bitwise OR of their individual level bits.
- R8: Level lines 0, 2, 3, 5, 7, 9, 11, 12, 13 and 15 are never high.
- R9: The level lines change on the first clock edge after a request change or a register write, and not before it.
- R10: A read strobe returns the stored byte on the read data bus one cycle later. The upper bus bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 8 | Level-sensitive interrupt requests |
| wr_en_i | input | 1 | Control register write strobe |
| wr_data_i | input | 8 | Control register write data |
| rd_en_i | input | 1 | Control register read strobe |
| rd_data_o | output | 32 | Zero-extended read data, valid the cycle after rd_en_i |
| pil_o | output | 16 | Registered priority-level lines |

## Verification
Every result of this block is due exactly one clock edge after its cause: level lines after a request change or a register write, read data after a read strobe. Each task drives its stimulus just after a falling edge. It then waits for one rising edge and samples at the next falling edge. For latency checks it also samples shortly after the stimulus, before the rising edge, to confirm that the old value still holds. A full sweep over all 256 request patterns compares the level lines against a table kept inside the bench.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;
   localparam int unsigned REQ_N   = 8;
   localparam int unsigned LVL_W   = 4;
   localparam int unsigned LVL_N   = 16;
   localparam int unsigned CTL_W   = 8;
   localparam int unsigned BUS_W   = 32;
   localparam int unsigned EN_BIT  = 0;
   localparam logic [CTL_W-1:0] CTL_RST  = 8'h01;
   localparam logic [CTL_W-1:0] WR_KEEP  = 8'hBF;
   // request bit g uses nibble g; level 0 marks an inert input
   localparam logic [REQ_N*LVL_W-1:0] DEF_MAP =
      {4'd14, 4'd0, 4'd10, 4'd8, 4'd6, 4'd4, 4'd1, 4'd0};
endpackage

// File: rtl/irq_pend_track.sv
module irq_pend_track #(
   parameter int unsigned REQ_N = lvl_irq_pkg::REQ_N,
   parameter int unsigned LVL_W = lvl_irq_pkg::LVL_W,
   parameter logic [REQ_N*LVL_W-1:0] MAP = lvl_irq_pkg::DEF_MAP
) (
   input  logic [REQ_N-1:0] req_i,
   output logic [REQ_N-1:0] pend_o
);
   for (genvar g = 0; g < REQ_N; g++) begin : g_bit
      localparam logic [LVL_W-1:0] LV = MAP[g*LVL_W +: LVL_W];
      if (LV == '0) begin : g_inert
         assign pend_o[g] = 1'b0;
      end else begin : g_live
         assign pend_o[g] = req_i[g];
      end
   end
endmodule

// File: rtl/irq_ctl_reg.sv
module irq_ctl_reg #(
   parameter int unsigned CTL_W = lvl_irq_pkg::CTL_W,
   parameter int unsigned BUS_W = lvl_irq_pkg::BUS_W,
   parameter logic [CTL_W-1:0] RST_VAL = lvl_irq_pkg::CTL_RST,
   parameter logic [CTL_W-1:0] KEEP    = lvl_irq_pkg::WR_KEEP
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             wr_en_i,
   input  logic [CTL_W-1:0] wr_data_i,
   input  logic             rd_en_i,
   output logic [BUS_W-1:0] rd_data_o,
   output logic [CTL_W-1:0] ctl_q_o,
   output logic [CTL_W-1:0] ctl_d_o
);
   localparam int unsigned PAD_W = BUS_W - CTL_W;

   if (BUS_W < CTL_W) begin : g_bad_bus
      $error("irq_ctl_reg: bus narrower than control register");
   end

   logic [CTL_W-1:0] ctl_q;
   logic [BUS_W-1:0] rd_q;

   always_comb begin
      ctl_d_o = ctl_q;
      if (wr_en_i) ctl_d_o = wr_data_i & KEEP;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ctl_q <= RST_VAL;
      else         ctl_q <= ctl_d_o;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      rd_q <= '0;
      else if (rd_en_i) rd_q <= {{PAD_W{1'b0}}, ctl_q};
   end

   assign ctl_q_o   = ctl_q;
   assign rd_data_o = rd_q;

   // R5
   locked_bits_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctl_q & ~KEEP) == '0);
   // R5
   wr_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i |=> ctl_q[0] == $past(wr_data_i[0]));
   // R10
   rd_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_en_i |=> rd_data_o[BUS_W-1:CTL_W] == '0);
endmodule

// File: rtl/irq_lvl_map.sv
module irq_lvl_map #(
   parameter int unsigned REQ_N = lvl_irq_pkg::REQ_N,
   parameter int unsigned LVL_W = lvl_irq_pkg::LVL_W,
   parameter int unsigned LVL_N = lvl_irq_pkg::LVL_N,
   parameter logic [REQ_N*LVL_W-1:0] MAP = lvl_irq_pkg::DEF_MAP
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [REQ_N-1:0] pend_i,
   input  logic             en_i,
   output logic [LVL_N-1:0] pil_o
);
   function automatic logic [LVL_N-1:0] used_levels();
      logic [LVL_N-1:0] u = '0;
      for (int k = 0; k < REQ_N; k++) begin
         if (MAP[k*LVL_W +: LVL_W] != '0) u[MAP[k*LVL_W +: LVL_W]] = 1'b1;
      end
      return u;
   endfunction

   localparam logic [LVL_N-1:0] USED = used_levels();

   if (LVL_N != (1 << LVL_W)) begin : g_bad_lvl
      $error("irq_lvl_map: level count must be 2**LVL_W");
   end

   logic [LVL_N-1:0] part [REQ_N];
   logic [LVL_N-1:0] pil_d;
   logic [LVL_N-1:0] pil_q;

   for (genvar g = 0; g < REQ_N; g++) begin : g_req
      localparam logic [LVL_W-1:0] LV = MAP[g*LVL_W +: LVL_W];
      if (LV == '0) begin : g_inert
         assign part[g] = '0;
      end else begin : g_live
         assign part[g] = pend_i[g] ? (LVL_N'(1) << LV) : '0;
      end
   end

   always_comb begin
      pil_d = '0;
      for (int k = 0; k < REQ_N; k++) pil_d = pil_d | part[k];
      if (!en_i) pil_d = '0;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pil_q <= '0;
      else         pil_q <= pil_d;
   end

   assign pil_o = pil_q;

   // R3
   level_zero_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pil_q[0] == 1'b0);
   // R8
   unmapped_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pil_q & ~USED) == '0);
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl #(
   parameter int unsigned REQ_N = lvl_irq_pkg::REQ_N,
   parameter int unsigned LVL_W = lvl_irq_pkg::LVL_W,
   parameter int unsigned LVL_N = lvl_irq_pkg::LVL_N,
   parameter int unsigned CTL_W = lvl_irq_pkg::CTL_W,
   parameter int unsigned BUS_W = lvl_irq_pkg::BUS_W,
   parameter int unsigned EN_BIT = lvl_irq_pkg::EN_BIT,
   parameter logic [REQ_N*LVL_W-1:0] MAP = lvl_irq_pkg::DEF_MAP
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [REQ_N-1:0] req_i,
   input  logic             wr_en_i,
   input  logic [CTL_W-1:0] wr_data_i,
   input  logic             rd_en_i,
   output logic [BUS_W-1:0] rd_data_o,
   output logic [LVL_N-1:0] pil_o
);
   if (EN_BIT >= CTL_W) begin : g_bad_en
      $error("lvl_irq_ctrl: enable bit outside control register");
   end

   logic [REQ_N-1:0] pend;
   logic [CTL_W-1:0] ctl_q;
   logic [CTL_W-1:0] ctl_d;

   irq_pend_track #(.REQ_N(REQ_N), .LVL_W(LVL_W), .MAP(MAP)) u_track (
      .req_i  (req_i),
      .pend_o (pend)
   );

   irq_ctl_reg #(.CTL_W(CTL_W), .BUS_W(BUS_W)) u_ctl (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (wr_en_i),
      .wr_data_i (wr_data_i),
      .rd_en_i   (rd_en_i),
      .rd_data_o (rd_data_o),
      .ctl_q_o   (ctl_q),
      .ctl_d_o   (ctl_d)
   );

   irq_lvl_map #(.REQ_N(REQ_N), .LVL_W(LVL_W), .LVL_N(LVL_N), .MAP(MAP)) u_map (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pend_i (pend),
      .en_i   (ctl_d[EN_BIT]),
      .pil_o  (pil_o)
   );

   // R6
   disabled_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ctl_q[EN_BIT] && !wr_en_i) |=> pil_o == '0);
   // R4
   idle_req_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend == '0) |=> pil_o == '0);
   // R9
   pil_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($stable(req_i) && !wr_en_i && !$past(wr_en_i) && $past(rst_ni)) |=> $stable(pil_o));
endmodule

// File: tb/lvl_irq_ctrl_test.sv
module lvl_irq_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  req = '0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_data = '0;
   logic        rd_en = 1'b0;
   logic [31:0] rd_data;
   logic [15:0] pil;
   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   lvl_irq_ctrl uut (
      .clk_i(clk), .rst_ni(rst_n), .req_i(req), .wr_en_i(wr_en),
      .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_data_o(rd_data), .pil_o(pil)
   );

   function automatic int lvl_of(int b);
      case (b)
         1: return 1;  2: return 4;  3: return 6;
         4: return 8;  5: return 10; 7: return 14;
         default: return 0;
      endcase
   endfunction

   function automatic logic [15:0] model(logic [7:0] r, logic [7:0] c);
      logic [15:0] o = '0;
      if (!c[0]) return '0;
      for (int b = 0; b < 8; b++)
         if (r[b] && lvl_of(b) != 0) o[lvl_of(b)] = 1'b1;
      return o;
   endfunction

   task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
      end
   endtask

   task automatic set_req(logic [7:0] v);
      req = v;
      @(posedge clk); @(negedge clk);
   endtask

   task automatic wr_ctl(logic [7:0] v);
      wr_en = 1'b1; wr_data = v;
      @(posedge clk); @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_ctl(output logic [31:0] v);
      rd_en = 1'b1;
      @(posedge clk); @(negedge clk);
      rd_en = 1'b0;
      v = rd_data;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      chk("R1 pil after reset", 32'(pil), 32'h0);
      rd_ctl(v);
      chk("R1 ctl after reset", v, 32'h01);
   endtask

   task automatic t_single();
      for (int b = 0; b < 8; b++) begin
         if (lvl_of(b) == 0) continue;
         set_req(8'(1 << b));
         chk($sformatf("R2 bit %0d", b), 32'(pil), 32'(1 << lvl_of(b)));
      end
      set_req('0);
   endtask

   task automatic t_latency();
      set_req(8'h10);
      req = 8'h20;
      #2;
      chk("R9 before edge", 32'(pil), 32'h0100);
      @(posedge clk); @(negedge clk);
      chk("R9 after edge", 32'(pil), 32'h0400);
      wr_en = 1'b1; wr_data = 8'h00;
      #2;
      chk("R9 write before edge", 32'(pil), 32'h0400);
      @(posedge clk); @(negedge clk);
      wr_en = 1'b0;
      chk("R9 write after edge", 32'(pil), 32'h0);
      wr_ctl(8'h01);
      set_req('0);
   endtask

   task automatic t_dead();
      set_req(8'h41);
      chk("R3 inert alone", 32'(pil), 32'h0);
      set_req(8'h43);
      chk("R3 inert with live", 32'(pil), 32'h0002);
      set_req('0);
   endtask

   task automatic t_follow();
      set_req(8'h80);
      chk("R4 held", 32'(pil), 32'h4000);
      set_req('0);
      chk("R4 dropped", 32'(pil), 32'h0);
   endtask

   task automatic t_multi();
      set_req(8'hBE);
      chk("R7 or of levels", 32'(pil), 32'h4552);
      set_req(8'h0C);
      chk("R7 pair", 32'(pil), 32'h0050);
      set_req('0);
   endtask

   task automatic t_enable();
      set_req(8'hFF);
      wr_ctl(8'hFE);
      chk("R6 disabled", 32'(pil), 32'h0);
      set_req(8'h82);
      chk("R6 disabled new req", 32'(pil), 32'h0);
      wr_ctl(8'h01);
      chk("R6 re-enabled", 32'(pil), 32'h4002);
      set_req('0);
   endtask

   task automatic t_mask();
      logic [31:0] v;
      wr_ctl(8'hFF);
      rd_ctl(v);
      chk("R5 bit6 dropped", v, 32'hBF);
      wr_ctl(8'h40);
      rd_ctl(v);
      chk("R5 only bit6", v, 32'h00);
      wr_ctl(8'hA5);
      rd_ctl(v);
      chk("R10 zero-extended", v, 32'h000000A5);
      wr_ctl(8'h01);
   endtask

   task automatic t_sweep();
      int bad = 0;
      for (int p = 0; p < 256; p++) begin
         set_req(8'(p));
         if (pil !== model(8'(p), 8'h01)) begin
            bad++;
            $display("FAIL R8 pattern 0x%0h: got 0x%0h expected 0x%0h",
                     p, pil, model(8'(p), 8'h01));
         end
         if ((pil & 16'hBAAD) != 0) bad++;
      end
      n_chk++;
      if (bad != 0) n_bad++;
      set_req('0);
   endtask

   initial begin
      #2000000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got hang expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      @(negedge clk); @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_single();
      t_latency();
      t_dead();
      t_follow();
      t_multi();
      t_enable();
      t_mask();
      t_sweep();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule